// File: doc/BRIEF.md
# Self-Repairing Triplicated Counter

This block is a 16-bit up-counter hardened against single upsets by holding its state three times. Each of the three copies computes its next value from the bitwise two-of-three majority of all three current copies, not from its own register. A copy that gets corrupted is therefore outvoted at once and overwritten with the agreed value at the next clock edge. The voted count keeps running through the repair without a gap. The price is one voter level in every copy's next-state path.

The counter has a synchronous reset, an enable that chooses between advancing and holding, a voted count output and a flag that shows when the copies disagree. A fault-injection port is included so that a test can disturb one chosen copy. It takes a strobe, a copy selector and a bit mask. The mask is XORed into the chosen copy's register in place of its normal next value.

Each cycle, a small decoder picks one of three named step actions: CLEAR, HOLD or ADVANCE. Reset takes priority and gives CLEAR. Otherwise a high enable gives ADVANCE and a low enable gives HOLD. All three copies apply the same step action to the voted word.

Top module: `tmr_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, all copies are cleared: after that edge `count` reads 0 and `mismatch` reads 0.
- R2: With `en` high and `rst` low, `count` increases by exactly 1 at every rising edge.
- R3: With `en` low and `rst` low, `count` keeps its value across the edge.
- R4: The count wraps from 16'hFFFF to 16'h0000 when it advances.
- R5: When `inj_valid` is high at an edge and `inj_sel` is 0, 1 or 2, copy number `inj_sel` stores its next value XORed with `inj_mask`. `count` is unaffected and still follows an unprotected reference counter.
- R6: `mismatch` is high after an edge exactly when that edge injected a nonzero mask into copy 0, 1 or 2. Otherwise it is low.
- R7: A corrupted copy is resynchronized at the next edge. Injections into different copies on consecutive edges, including the same bit each time, leave `count` equal to the reference counter, and `mismatch` is low after the first edge with no injection.
- R8: `inj_sel` value 3 selects no copy. An injection with it changes neither `count` nor `mismatch`.
- R9: An injection that coincides with `rst` high is ignored: the copies clear and `mismatch` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds the count |
| inj_valid | input | 1 | Fault-injection strobe for this edge |
| inj_sel | input | 2 | Copy to corrupt (0..2); 3 selects none |
| inj_mask | input | 16 | Bits to invert in the selected copy |
| count | output | 16 | Majority-voted count |
| mismatch | output | 1 | High while the three copies disagree |

## Verification
On every cycle, the embedded properties check the reset value, the hold and the advance of the voted count, the wrap, and the rule that disagreement appears only after an effective injection. Two behaviours depend on a sequence of stimulus and are shown only by the bench's scenarios. The first is that the voted count stays equal to a reference counter through bursts of injections spread over different copies. The second is that disagreement clears one edge after the last injection. The bench's scenarios also show that selector value 3 and injections during reset have no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        STEP_CLEAR   = 2'd0,
        STEP_HOLD    = 2'd1,
        STEP_ADVANCE = 2'd2
    } step_t;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int W = 16
) (
    input  logic [W-1:0] copy_a,
    input  logic [W-1:0] copy_b,
    input  logic [W-1:0] copy_c,
    output logic [W-1:0] voted,
    output logic         differ
);
    // bitwise two-of-three majority
    always_comb begin
        voted  = (copy_a & copy_b) | (copy_a & copy_c) | (copy_b & copy_c);
        differ = (copy_a != copy_b) || (copy_a != copy_c);
    end
endmodule

// File: rtl/tmr_replica.sv
module tmr_replica
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  step_t        step,
    input  logic [W-1:0] voted,
    input  logic         inj_hit,
    input  logic [W-1:0] inj_mask,
    output logic [W-1:0] q
);
    logic [W-1:0] flip;

    always_comb begin
        flip = inj_hit ? inj_mask : '0;
    end

    // next state always derived from the voted word, never from q itself
    always_ff @(posedge clk) begin
        unique case (step)
            STEP_CLEAR:   q <= '0;
            STEP_HOLD:    q <= voted ^ flip;
            STEP_ADVANCE: q <= (voted + W'(1)) ^ flip;
            default:      q <= '0;
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W     = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             inj_valid,
    input  logic [SEL_W-1:0] inj_sel,
    input  logic [W-1:0]     inj_mask,
    output logic [W-1:0]     count,
    output logic             mismatch
);
    localparam int COPIES = 3;
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    step_t        step;
    logic [W-1:0] copy_q [COPIES];
    logic [W-1:0] voted;
    logic         differ;

    // step action decoder: reset has priority over enable
    always_comb begin
        if (rst)     step = STEP_CLEAR;
        else if (en) step = STEP_ADVANCE;
        else         step = STEP_HOLD;
    end

    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        logic hit;
        always_comb begin
            hit = inj_valid && (inj_sel == SEL_W'(i));
        end
        tmr_replica #(.W(W)) replica_i (
            .clk      (clk),
            .step     (step),
            .voted    (voted),
            .inj_hit  (hit),
            .inj_mask (inj_mask),
            .q        (copy_q[i])
        );
    end

    tmr_voter #(.W(W)) voter_i (
        .copy_a (copy_q[0]),
        .copy_b (copy_q[1]),
        .copy_c (copy_q[2]),
        .voted  (voted),
        .differ (differ)
    );

    always_comb begin
        count    = voted;
        mismatch = differ;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (count == '0 && !mismatch)); // R1
    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (rst) en |=> count == W'($past(count) + W'(1))); // R2
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst) !en |=> count == $past(count)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst) (en && count == ALL_ONES) |=> count == '0); // R4
    AST_MISMATCH_CAUSE: assert property (@(posedge clk) disable iff (rst) !(inj_valid && inj_sel != SEL_W'(COPIES) && inj_mask != '0) |=> !mismatch); // R6
endmodule

// File: tb/tmr_counter_tb.sv
module tmr_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        inj_valid = 1'b0;
    logic [1:0]  inj_sel = 2'd0;
    logic [15:0] inj_mask = 16'd0;
    logic [15:0] count;
    logic        mismatch;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;
    logic [15:0] ref_cnt = 16'd0;

    always #2 clk = ~clk;

    tmr_counter dut_i (
        .clk(clk), .rst(rst), .en(en), .inj_valid(inj_valid),
        .inj_sel(inj_sel), .inj_mask(inj_mask),
        .count(count), .mismatch(mismatch)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge
    task automatic step(input bit r, input bit e, input bit iv, input logic [1:0] s,
                        input logic [15:0] m, input string tag);
        bit exp_mis;
        rst = r; en = e; inj_valid = iv; inj_sel = s; inj_mask = m;
        @(posedge clk);
        if (r) ref_cnt = 16'd0;
        else if (e) ref_cnt = ref_cnt + 16'd1;
        exp_mis = !r && iv && (s != 2'd3) && (m != 16'd0);
        @(negedge clk);
        chk(count == ref_cnt, {tag, " count"}, int'(count), int'(ref_cnt));
        chk(mismatch == exp_mis, {tag, " mismatch"}, int'(mismatch), int'(exp_mis));
    endtask

    task automatic t_reset();
        step(1, 0, 0, 0, 0, "R1");
        step(1, 1, 0, 0, 0, "R1");
    endtask

    task automatic t_count();
        for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 0, "R2");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, "R2");
    endtask

    task automatic t_inject_single();
        for (int c = 0; c < 3; c++) begin
            step(0, 1, 1, 2'(c), 16'h8001, "R5");
            step(0, 1, 0, 0, 0, "R7");
            step(0, 0, 1, 2'(c), 16'hFFFF, "R5");
            step(0, 0, 0, 0, 0, "R7");
        end
        step(0, 1, 1, 2'd1, 16'h0000, "R6");
    endtask

    task automatic t_inject_burst();
        for (int k = 0; k < 12; k++) step(0, 1, 1, 2'(k % 3), 16'h0004, "R7");
        step(0, 1, 0, 0, 0, "R7");
        for (int k = 0; k < 6; k++) step(0, k[0], 1, 2'(2 - (k % 3)), 16'(16'h1 << k), "R7");
        step(0, 0, 0, 0, 0, "R7");
    endtask

    task automatic t_sel_none();
        step(0, 1, 1, 2'd3, 16'hFFFF, "R8");
        step(0, 0, 1, 2'd3, 16'h00F0, "R8");
    endtask

    task automatic t_inject_in_reset();
        step(1, 1, 1, 2'd0, 16'h5555, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(0, 1, 0, 0, 0, "R9");
    endtask

    task automatic t_wrap();
        while (ref_cnt != 16'hFFFE) step(0, 1, 0, 0, 0, "R4");
        step(0, 1, 1, 2'd2, 16'hFFFF, "R4");
        step(0, 1, 0, 0, 0, "R4");
        chk(count == 16'h0000, "R4 wrap value", int'(count), 0);
        step(0, 1, 0, 0, 0, "R4");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_count();
        t_hold();
        t_inject_single();
        t_inject_burst();
        t_sel_none();
        t_inject_in_reset();
        t_wrap();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule